// File: doc/BRIEF.md
# Multi-Channel Shared-Memory Receive Buffer

This block buffers received words between a stream producer and a local-bus consumer. Several independent logical FIFO channels live in one dual-port memory. The memory is cut into equal contiguous regions, one per channel. Each region keeps its own write pointer, read pointer and occupancy count, and both pointers wrap inside that region. The producer writes only through the memory's write port. The consumer reads only through its read port.

On every request each side names a channel. Every request is answered one cycle later with either an acknowledge or an error acknowledge. The consumer can pop a data word, or it can read a status word that holds the channel's occupancy. Fill flags and a vacancy count are computed continuously for the channel that the producer currently selects. A burst qualifier on each side tells the block whether a request held over a second cycle is a new transfer or the tail of the one before it. Everything runs on one clock.

Top module: `mcrx_fifo`

## Requirements
- R1: After reset every channel is empty. No acknowledge or error acknowledge is asserted on either side. With channel 0 selected, the write side shows vacancy equal to the channel depth (TOTAL_WORDS/NUM_CH) and full, almost-full and half-full are low.
- R2: On each side, the channel-valid output is high exactly when that side's channel number is below NUM_CH. A request to any other channel gets an error acknowledge one cycle later and changes no channel state.
- R3: A write to a valid channel that is not full is acknowledged one cycle later, and its word is stored. A write to a full channel gets an error acknowledge one cycle later and changes nothing.
- R4: A data read from a valid channel that is not empty returns the oldest word of that channel, together with the acknowledge, one cycle after the request. A data read from an empty channel gets an error acknowledge and changes nothing.
- R5: A status read of a valid channel is acknowledged one cycle later. Read data carries that channel's occupancy at the request cycle, zero-extended, and nothing is popped. When the status and data read requests are both high, the status read is performed.
- R6: The write-side flags follow the selected write channel combinationally. Full means occupancy equals depth. Almost-full means occupancy equals depth minus 1. Half-full means twice the occupancy is at least the depth. Vacancy is depth minus occupancy. For an invalid channel all flags are low and vacancy is 0.
- R7: With burst high, a request in every consecutive cycle is serviced. With burst low, a request that is present while the same side's acknowledge or error acknowledge is high is ignored, and it is answered with neither.
- R8: An accepted write and an accepted read on the same channel in the same cycle leave that channel's occupancy unchanged. Traffic on one channel does not alter another channel's occupancy or data.
- R9: Pointers wrap inside each channel's region, so data order stays intact across repeated fill and drain passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ch | input | SEL_W | Write-side channel number |
| wr_burst | input | 1 | Write burst qualifier |
| wr_req | input | 1 | Write request |
| wr_data | input | DATA_W | Write data word |
| wr_ack | output | 1 | Write accepted (one cycle after request) |
| wr_err | output | 1 | Write rejected (one cycle after request) |
| wr_ch_ok | output | 1 | Write channel number is valid |
| wr_full | output | 1 | Selected write channel is full |
| wr_afull | output | 1 | Selected write channel has one free word |
| wr_hfull | output | 1 | Selected write channel is at least half full |
| wr_vacancy | output | CNT_W | Free words in selected write channel |
| rd_ch | input | SEL_W | Read-side channel number |
| rd_burst | input | 1 | Read burst qualifier |
| rd_data_req | input | 1 | Data read (pop) request |
| rd_stat_req | input | 1 | Status (occupancy) read request |
| rd_ack | output | 1 | Read accepted (one cycle after request) |
| rd_err | output | 1 | Read rejected (one cycle after request) |
| rd_ch_ok | output | 1 | Read channel number is valid |
| rd_data | output | DATA_W | Read data or status word, valid with rd_ack |

## Verification
The channel-valid outputs and the four write-side flags are combinational. The bench samples them in the same cycle that it drives the inputs, just after the drive and before the next rising edge, and compares them with the occupancy its model holds before that cycle's update. The acknowledges, error acknowledges and read data are registered once and are therefore due one edge after the request. The driver queues one expected entry per driven cycle, and the monitor pops and compares that entry a moment after the following rising edge. Because the model computes each outcome from its state before the cycle, it handles same-cycle write-and-read, held non-burst requests and full/empty rejections in the cycle order the RTL uses.

// File: rtl/mcrx_pkg.sv
package mcrx_pkg;

    // width able to hold every occupancy value 0..depth of one channel
    function automatic int occ_width(input int num_ch, input int total_words);
        return $clog2(total_words / num_ch + 1);
    endfunction

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_DATA = 2'd1,
        RK_STAT = 2'd2
    } rd_kind_e;

endpackage

// File: rtl/mcrx_dpram.sv
module mcrx_dpram #(
    parameter int WORDS  = 64,
    parameter int DATA_W = 16,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem_q [WORDS];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        if (re_i) begin
            rdata_q <= mem_q[raddr_i];
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/mcrx_chan_state.sv
module mcrx_chan_state #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic [PTR_W-1:0] wptr_o,
    output logic [PTR_W-1:0] rptr_o,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] count;
    } chan_t;

    chan_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (push_i) begin
            s_d.wptr = (s_q.wptr == PTR_W'(DEPTH - 1)) ? '0 : s_q.wptr + 1'b1;
        end
        if (pop_i) begin
            s_d.rptr = (s_q.rptr == PTR_W'(DEPTH - 1)) ? '0 : s_q.rptr + 1'b1;
        end
        case ({push_i, pop_i})
            2'b10:   s_d.count = s_q.count + 1'b1;
            2'b01:   s_d.count = s_q.count - 1'b1;
            default: s_d.count = s_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wptr_o  = s_q.wptr;
    assign rptr_o  = s_q.rptr;
    assign count_o = s_q.count;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= CNT_W'(DEPTH));
    assert_push_not_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (s_q.count != CNT_W'(DEPTH)));
    assert_pop_not_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (s_q.count != '0));
    assert_pushpop_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> $stable(s_q.count));

endmodule

// File: rtl/mcrx_fifo.sv
module mcrx_fifo #(
    parameter int NUM_CH      = 4,
    parameter int TOTAL_WORDS = 64,
    parameter int DATA_W      = 16,
    localparam int DEPTH  = TOTAL_WORDS / NUM_CH,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int SEL_W  = CH_W + 1,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int ADDR_W = $clog2(TOTAL_WORDS),
    localparam int CNT_W  = mcrx_pkg::occ_width(NUM_CH, TOTAL_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  wr_ch,
    input  logic              wr_burst,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ack,
    output logic              wr_err,
    output logic              wr_ch_ok,
    output logic              wr_full,
    output logic              wr_afull,
    output logic              wr_hfull,
    output logic [CNT_W-1:0]  wr_vacancy,
    input  logic [SEL_W-1:0]  rd_ch,
    input  logic              rd_burst,
    input  logic              rd_data_req,
    input  logic              rd_stat_req,
    output logic              rd_ack,
    output logic              rd_err,
    output logic              rd_ch_ok,
    output logic [DATA_W-1:0] rd_data
);

    import mcrx_pkg::*;

    typedef struct packed {
        logic              wr_ack;
        logic              wr_err;
        logic              rd_ack;
        logic              rd_err;
        logic              sel_stat;
        logic [DATA_W-1:0] stat_val;
    } top_t;

    top_t t_d, t_q;

    logic [PTR_W-1:0] wptr  [NUM_CH];
    logic [PTR_W-1:0] rptr  [NUM_CH];
    logic [CNT_W-1:0] count [NUM_CH];
    logic [NUM_CH-1:0] push_vec, pop_vec;

    logic [CH_W-1:0]   wr_idx, rd_idx;
    logic [CNT_W-1:0]  wr_cnt, rd_cnt;
    logic              wr_live, rd_live, push_ok, pop_ok, stat_ok;
    rd_kind_e          rd_kind;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_dout;

    // channel decode and selected-channel occupancy
    always_comb begin
        wr_idx   = wr_ch[CH_W-1:0];
        rd_idx   = rd_ch[CH_W-1:0];
        wr_ch_ok = (int'(wr_ch) < NUM_CH);
        rd_ch_ok = (int'(rd_ch) < NUM_CH);
        wr_cnt   = wr_ch_ok ? count[wr_idx] : '0;
        rd_cnt   = rd_ch_ok ? count[rd_idx] : '0;
    end

    // continuous flags for the write-side channel
    always_comb begin
        wr_full    = wr_ch_ok && (wr_cnt == CNT_W'(DEPTH));
        wr_afull   = wr_ch_ok && (wr_cnt == CNT_W'(DEPTH - 1));
        wr_hfull   = wr_ch_ok && ((int'(wr_cnt) * 2) >= DEPTH);
        wr_vacancy = wr_ch_ok ? CNT_W'(DEPTH) - wr_cnt : '0;
    end

    // request qualification, acceptance and next registered state
    always_comb begin
        wr_live = wr_req && (wr_burst || !(t_q.wr_ack || t_q.wr_err));
        rd_live = (rd_data_req || rd_stat_req)
                  && (rd_burst || !(t_q.rd_ack || t_q.rd_err));
        if (!rd_live)         rd_kind = RK_NONE;
        else if (rd_stat_req) rd_kind = RK_STAT;
        else                  rd_kind = RK_DATA;

        push_ok = wr_live && wr_ch_ok && !wr_full;
        pop_ok  = (rd_kind == RK_DATA) && rd_ch_ok && (rd_cnt != '0);
        stat_ok = (rd_kind == RK_STAT) && rd_ch_ok;

        t_d          = t_q;
        t_d.wr_ack   = push_ok;
        t_d.wr_err   = wr_live && !push_ok;
        t_d.rd_ack   = pop_ok || stat_ok;
        t_d.rd_err   = rd_live && !(pop_ok || stat_ok);
        t_d.sel_stat = stat_ok;
        t_d.stat_val = stat_ok ? DATA_W'(rd_cnt) : '0;

        mem_waddr = ADDR_W'(int'(wr_idx) * DEPTH + int'(wptr[wr_idx]));
        mem_raddr = ADDR_W'(int'(rd_idx) * DEPTH + int'(rptr[rd_idx]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign push_vec[g] = push_ok && (wr_idx == CH_W'(g));
        assign pop_vec[g]  = pop_ok  && (rd_idx == CH_W'(g));
        mcrx_chan_state #(.DEPTH(DEPTH)) u_state (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (push_vec[g]),
            .pop_i   (pop_vec[g]),
            .wptr_o  (wptr[g]),
            .rptr_o  (rptr[g]),
            .count_o (count[g])
        );
    end

    mcrx_dpram #(.WORDS(TOTAL_WORDS), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .we_i    (push_ok),
        .waddr_i (mem_waddr),
        .wdata_i (wr_data),
        .re_i    (pop_ok),
        .raddr_i (mem_raddr),
        .rdata_o (mem_dout)
    );

    assign wr_ack  = t_q.wr_ack;
    assign wr_err  = t_q.wr_err;
    assign rd_ack  = t_q.rd_ack;
    assign rd_err  = t_q.rd_err;
    assign rd_data = !t_q.rd_ack ? '0 : (t_q.sel_stat ? t_q.stat_val : mem_dout);

    assert_bad_wr_ch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ch_ok) |=> !wr_ack);
    assert_bad_rd_ch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data_req || rd_stat_req) && !rd_ch_ok) |=> !rd_ack);
    assert_full_no_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full |-> (wr_vacancy == '0) && !wr_afull);
    assert_stat_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && t_q.sel_stat) |-> (rd_data <= DATA_W'(DEPTH)));
    assert_held_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_burst && (wr_ack || wr_err)) |=> !(wr_ack || wr_err));
    assert_one_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_ack, wr_err}) && $onehot0({rd_ack, rd_err}));

endmodule

// File: tb/mcrx_fifo_test.sv
module mcrx_fifo_test;

    localparam int NCH = 4;
    localparam int DEP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  wr_ch = '0, rd_ch = '0;
    logic        wr_burst = 1'b0, wr_req = 1'b0, rd_burst = 1'b0;
    logic        rd_data_req = 1'b0, rd_stat_req = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_ack, wr_err, wr_ch_ok, wr_full, wr_afull, wr_hfull;
    logic [4:0]  wr_vacancy;
    logic        rd_ack, rd_err, rd_ch_ok;
    logic [15:0] rd_data;

    mcrx_fifo uut (
        .clk(clk), .rst_n(rst_n),
        .wr_ch(wr_ch), .wr_burst(wr_burst), .wr_req(wr_req), .wr_data(wr_data),
        .wr_ack(wr_ack), .wr_err(wr_err), .wr_ch_ok(wr_ch_ok), .wr_full(wr_full),
        .wr_afull(wr_afull), .wr_hfull(wr_hfull), .wr_vacancy(wr_vacancy),
        .rd_ch(rd_ch), .rd_burst(rd_burst), .rd_data_req(rd_data_req),
        .rd_stat_req(rd_stat_req), .rd_ack(rd_ack), .rd_err(rd_err),
        .rd_ch_ok(rd_ch_ok), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic        wack, werr, rack, rerr;
        logic [15:0] rdata;
    } exp_t;

    exp_t        expq [$];
    string       tagq [$];
    logic [15:0] mq [NCH][$];
    logic        mw_prev = 0, mr_prev = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int occ(input logic [2:0] ch);
        return (int'(ch) < NCH) ? mq[ch].size() : -1;
    endfunction

    // driver: drive one cycle, check combinational outputs, queue expectations
    task automatic step(input logic [2:0] wch, input logic wb, input logic wq,
                        input logic [15:0] wd, input logic [2:0] rch, input logic rb,
                        input logic rdq, input logic rsq, input string tag);
        exp_t e;
        int   o;
        logic wlive, rlive, do_push;
        @(negedge clk);
        wr_ch = wch; wr_burst = wb; wr_req = wq; wr_data = wd;
        rd_ch = rch; rd_burst = rb; rd_data_req = rdq; rd_stat_req = rsq;
        #0.5;
        o = occ(wch);
        chk({"R2 wr_ch_ok ", tag}, wr_ch_ok, o >= 0);
        chk({"R2 rd_ch_ok ", tag}, rd_ch_ok, int'(rch) < NCH);
        chk({"R6 full ", tag},  wr_full,  o == DEP);
        chk({"R6 afull ", tag}, wr_afull, o == DEP - 1);
        chk({"R6 hfull ", tag}, wr_hfull, o >= 0 && 2 * o >= DEP);
        chk({"R6 vacancy ", tag}, wr_vacancy, (o >= 0) ? DEP - o : 0);
        e = '{default: '0};
        wlive = wq && (wb || !mw_prev);
        rlive = (rdq || rsq) && (rb || !mr_prev);
        do_push = wlive && o >= 0 && o < DEP;
        e.wack = do_push;
        e.werr = wlive && !do_push;
        if (rlive) begin
            if (int'(rch) >= NCH) e.rerr = 1;
            else if (rsq) begin e.rack = 1; e.rdata = 16'(mq[rch].size()); end
            else if (mq[rch].size() == 0) e.rerr = 1;
            else begin e.rack = 1; e.rdata = mq[rch].pop_front(); end
        end
        if (do_push) mq[wch].push_back(wd);
        mw_prev = e.wack || e.werr;
        mr_prev = e.rack || e.rerr;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    task automatic idle();
        step(3'd0, 0, 0, '0, 3'd0, 0, 0, 0, "idle");
    endtask

    // monitor: answers are due one edge after the request
    always @(posedge clk) begin
        #1;
        if (expq.size() > 0) begin
            exp_t  e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            chk({"R3 wr_ack ", t}, wr_ack, e.wack);
            chk({"R3 wr_err ", t}, wr_err, e.werr);
            chk({"R4 rd_ack ", t}, rd_ack, e.rack);
            chk({"R4 rd_err ", t}, rd_err, e.rerr);
            if (e.rack) chk({"R4 R5 rd_data ", t}, rd_data, e.rdata);
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset wr_ack", wr_ack, 0);
        chk("R1 reset rd_ack", rd_ack, 0);
        chk("R1 reset wr_err", wr_err, 0);
        chk("R1 reset vacancy", wr_vacancy, DEP);
        chk("R1 reset full", wr_full, 0);
        chk("R1 reset hfull", wr_hfull, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 R6: burst fill channel 0 past full
        for (int i = 0; i < DEP + 1; i++)
            step(3'd0, 1, 1, 16'h0A00 + 16'(i), 3'd1, 0, 0, 0, "fill ch0");
        idle();
        // R5: status read, and status wins over data read
        step(3'd0, 0, 0, '0, 3'd0, 0, 0, 1, "R5 status ch0");
        idle();
        step(3'd0, 0, 0, '0, 3'd0, 0, 1, 1, "R5 status priority");
        idle();
        // R4: burst drain channel 0 past empty
        for (int i = 0; i < DEP + 1; i++)
            step(3'd0, 0, 0, '0, 3'd0, 1, 1, 0, "drain ch0");
        idle();
        // R2: invalid channels on both sides
        step(3'd5, 0, 1, 16'hDEAD, 3'd6, 0, 1, 0, "R2 invalid ch");
        idle();
        step(3'd4, 0, 0, '0, 3'd7, 0, 0, 1, "R2 invalid status");
        idle();
        // R7: non-burst write held for two cycles -> one transfer
        step(3'd1, 0, 1, 16'h1111, 3'd0, 0, 0, 0, "R7 held write");
        step(3'd1, 0, 1, 16'h1111, 3'd0, 0, 0, 0, "R7 held write tail");
        idle();
        step(3'd1, 0, 0, '0, 3'd1, 0, 1, 0, "R7 held read");
        step(3'd1, 0, 0, '0, 3'd1, 0, 1, 0, "R7 held read tail");
        idle();
        // R8: seed ch2, then simultaneous write+read on ch2, ch3 untouched
        for (int i = 0; i < 3; i++)
            step(3'd2, 1, 1, 16'h2200 + 16'(i), 3'd0, 0, 0, 0, "R8 seed ch2");
        step(3'd3, 0, 1, 16'h3333, 3'd0, 0, 0, 0, "R8 seed ch3");
        idle();
        for (int i = 0; i < 4; i++)
            step(3'd2, 1, 1, 16'h2300 + 16'(i), 3'd2, 1, 1, 0, "R8 push+pop ch2");
        idle();
        step(3'd2, 0, 0, '0, 3'd2, 0, 0, 1, "R8 status ch2");
        idle();
        step(3'd3, 0, 0, '0, 3'd3, 0, 0, 1, "R8 status ch3");
        idle();
        // R8: pop on an empty channel while writing it in the same cycle
        step(3'd1, 0, 1, 16'h1212, 3'd1, 0, 1, 0, "R8 empty pop with write");
        idle();
        // R9: repeated fill/drain passes on ch0 with offsets forcing wrap
        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < 11; i++)
                step(3'd0, 1, 1, 16'(p * 256 + i), 3'd0, 0, 0, 0, "R9 wrap fill");
            for (int i = 0; i < 11; i++)
                step(3'd0, 0, 0, '0, 3'd0, 1, 1, 0, "R9 wrap drain");
        end
        // drain what is left everywhere
        for (int c = 0; c < NCH; c++)
            for (int i = 0; i < 6; i++)
                step(3'(c), 0, 0, '0, 3'(c), 1, 1, 0, "final drain");
        repeat (3) idle();
        @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end

endmodule